// File: doc/BRIEF.md
# Trigger Latency and Jitter Monitor

This block measures how repeatably a scheduled actuation follows its execution marker. It watches three digital inputs: a timer compare fire, the execution marker, and the drive-start signal. Each input is synchronised and reduced to its rising edge, and every edge is stamped against a free-running tick counter. A marker edge opens an event. The next drive-start edge closes the event as a hit and records its latency in clock ticks. If no drive-start edge arrives within a programmable timeout, or if another marker edge arrives first, the event is closed as a miss.

Closed events are gathered into windows of N events, where N is configured between 10 and 30. When a window completes, the block captures the smallest latency, the largest latency, the spread between them, the latency sum and the hit count. Software divides the sum by the hit count to get the mean offset. The block also captures the miss count and the number of events whose arrival index was past their target index. The latest latency, the compare-to-marker delay and the signed index slip of the latest event can also be read. All results are read through a small combinational read port.

Top module: `trig_latency_monitor`

## Requirements
- R1: While reset is held, every readable register returns 0 and `winDone` is low.
- R2: Each input passes through a two-flop synchroniser and then a rising-edge detector, so a level held high gives exactly one edge. Latency is the number of clock cycles from a marker rising edge to the next drive-start rising edge. It is readable at address 0 after every hit.
- R3: Address 1 holds the number of cycles from the most recent compare-fire edge to the latest marker edge. The value is taken when that marker edge is accepted.
- R4: At each marker edge, the arrival and target indices are sampled. Address 2 holds arrival minus target, taken modulo 2^IDX_W and sign-extended. An event is late when arrival is greater than target (unsigned compare). Address 9 holds the number of late events in the last completed window.
- R5: A drive-start edge whose latency is no more than `timeoutCfg` closes the event as a hit. Otherwise the event closes as a miss in the cycle its latency reaches `timeoutCfg`+1, and a drive-start edge arriving at that point or later leaves address 0 unchanged. Address 8 holds the miss count of the last completed window.
- R6: A marker edge that arrives while an event is open closes that event as a miss and opens a new event. If a drive-start edge arrives in the same cycle as that marker edge, it closes the old event as a hit instead.
- R7: A drive-start edge that arrives while no event is open is ignored.
- R8: The window length is `winLen` clamped to the range 10 to 30. A window completes when the number of closed events (hits plus misses) reaches that length. `winDone` pulses high for one cycle, in the cycle after the closing edge is accepted.
- R9: On completion, the window results are captured, including the event that completed the window. Addresses 3, 4, 5, 6 and 7 hold minimum, maximum, maximum minus minimum, latency sum and hit count. The accumulators are cleared in that same cycle, so the next window starts empty. Addresses above 9 read 0.
- R10: A window with no hits reports minimum, maximum and spread as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmpIn | input | 1 | Timer compare fire, asynchronous |
| markIn | input | 1 | Execution marker, asynchronous |
| driveIn | input | 1 | Drive-start, asynchronous |
| arrIdx | input | IDX_W | Arrival event index, sampled at a marker edge |
| tgtIdx | input | IDX_W | Target event index, sampled at a marker edge |
| winLen | input | CFG_W | Requested window length, clamped to the range 10 to 30 |
| timeoutCfg | input | TS_W-1 | Largest latency, in cycles, that still counts as a hit |
| rdAddr | input | 4 | Read address |
| rdData | output | DATA_W | Read data, zero-extended (slip is sign-extended) |
| winDone | output | 1 | One-cycle pulse when a window's results are captured |

## Verification
The bench builds the block with its default parameters: a 16-bit tick counter, 8-bit indices, and window limits of 10 and 30. With these values, both clamp edges are reached by requesting 3 and 40. The 15-bit timeout is set to small values, 8 to 30 cycles, so the hit-at-limit, miss-at-limit-plus-one and back-to-back marker cases all occur within a few hundred cycles. Negative and positive index slips fit in the 8-bit index range. A full 30-event window of misses reaches the no-hit result case.

// File: rtl/tlm_pkg.sv
package tlm_pkg;

  typedef struct packed {
    logic openEvt;
    logic closeHit;
    logic closeMiss;
    logic winLatch;
  } tlm_strobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_OPEN = 1'b1
  } tlm_state_t;

  typedef enum logic [3:0] {
    RA_LAST_LAT  = 4'd0,
    RA_LAST_EXEC = 4'd1,
    RA_LAST_SLIP = 4'd2,
    RA_WIN_MIN   = 4'd3,
    RA_WIN_MAX   = 4'd4,
    RA_WIN_PP    = 4'd5,
    RA_WIN_SUM   = 4'd6,
    RA_WIN_HITS  = 4'd7,
    RA_WIN_MISS  = 4'd8,
    RA_WIN_LATE  = 4'd9
  } tlm_addr_t;

endpackage

// File: rtl/tlm_edge_sync.sv
module tlm_edge_sync #(
  parameter int N_IN = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [N_IN-1:0] rawIn,
  output logic [N_IN-1:0] riseOut
);

  for (genvar i = 0; i < N_IN; i++) begin : g_lane
    logic meta, stable, prev;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta   <= 1'b0;
        stable <= 1'b0;
        prev   <= 1'b0;
      end else begin
        meta   <= rawIn[i];
        stable <= meta;
        prev   <= stable;
      end
    end
    assign riseOut[i] = stable & ~prev;
  end

endmodule

// File: rtl/tlm_ctrl.sv
module tlm_ctrl
  import tlm_pkg::*;
#(
  parameter int TS_W    = 16,
  parameter int CFG_W   = 8,
  parameter int WIN_MIN = 10,
  parameter int WIN_MAX = 30,
  parameter int CNT_W   = $clog2(WIN_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              markRise,
  input  logic              driveRise,
  input  logic [TS_W-1:0]   curLat,
  input  logic [TS_W-2:0]   timeoutCfg,
  input  logic [CFG_W-1:0]  winLen,
  output tlm_strobe_t       strobe
);

  tlm_state_t       state, stateNext;
  logic [CNT_W-1:0] evCnt, winEff;
  logic             closeAny, inTime;

  // Clamp the requested window length into the supported range.
  always_comb begin
    if (winLen < CFG_W'(WIN_MIN))      winEff = CNT_W'(WIN_MIN);
    else if (winLen > CFG_W'(WIN_MAX)) winEff = CNT_W'(WIN_MAX);
    else                               winEff = winLen[CNT_W-1:0];
  end

  assign inTime = (curLat <= {1'b0, timeoutCfg});

  always_comb begin
    strobe           = '0;
    strobe.openEvt   = markRise;
    if (state == ST_OPEN) begin
      if (driveRise && inTime)        strobe.closeHit  = 1'b1;
      else if (markRise || !inTime)   strobe.closeMiss = 1'b1;
    end
    closeAny        = strobe.closeHit | strobe.closeMiss;
    strobe.winLatch = closeAny && (evCnt == winEff - CNT_W'(1));

    stateNext = state;
    if (markRise)      stateNext = ST_OPEN;
    else if (closeAny) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      evCnt <= '0;
    end else begin
      state <= stateNext;
      if (strobe.winLatch)  evCnt <= '0;
      else if (closeAny)    evCnt <= evCnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/tlm_datapath.sv
module tlm_datapath
  import tlm_pkg::*;
#(
  parameter int TS_W  = 16,
  parameter int IDX_W = 8,
  parameter int CNT_W = 5,
  parameter int SUM_W = TS_W + CNT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  tlm_strobe_t      strobe,
  input  logic             cmpRise,
  input  logic [IDX_W-1:0] arrIdx,
  input  logic [IDX_W-1:0] tgtIdx,
  output logic [TS_W-1:0]  curLat,
  output logic [TS_W-1:0]  lastLat,
  output logic [TS_W-1:0]  lastExec,
  output logic [IDX_W-1:0] lastSlip,
  output logic [TS_W-1:0]  resMin,
  output logic [TS_W-1:0]  resMax,
  output logic [TS_W-1:0]  resSpread,
  output logic [SUM_W-1:0] resSum,
  output logic [CNT_W-1:0] resHits,
  output logic [CNT_W-1:0] resMiss,
  output logic [CNT_W-1:0] resLate,
  output logic             winDone
);

  logic [TS_W-1:0]  tsNow, cmpTs, markTs;
  logic             lateFlag, closeAny;
  logic [TS_W-1:0]  accMin, accMax, nMin, nMax;
  logic [SUM_W-1:0] accSum, nSum;
  logic [CNT_W-1:0] accHits, accMiss, accLate, nHits, nMiss, nLate;

  assign curLat   = tsNow - markTs;
  assign closeAny = strobe.closeHit | strobe.closeMiss;

  // Accumulator values including the event closing this cycle.
  always_comb begin
    nMin  = accMin;
    nMax  = accMax;
    nSum  = accSum;
    nHits = accHits;
    nMiss = accMiss;
    nLate = accLate;
    if (strobe.closeHit) begin
      if (curLat < accMin) nMin = curLat;
      if (curLat > accMax) nMax = curLat;
      nSum  = accSum + SUM_W'(curLat);
      nHits = accHits + CNT_W'(1);
    end
    if (strobe.closeMiss)   nMiss = accMiss + CNT_W'(1);
    if (closeAny && lateFlag) nLate = accLate + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tsNow    <= '0;
      cmpTs    <= '0;
      markTs   <= '0;
      lateFlag <= 1'b0;
      lastLat  <= '0;
      lastExec <= '0;
      lastSlip <= '0;
    end else begin
      tsNow <= tsNow + TS_W'(1);
      if (cmpRise) cmpTs <= tsNow;
      if (strobe.closeHit) lastLat <= curLat;
      if (strobe.openEvt) begin
        markTs   <= tsNow;
        lateFlag <= (arrIdx > tgtIdx);
        lastSlip <= arrIdx - tgtIdx;
        lastExec <= tsNow - cmpTs;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accMin    <= '1;
      accMax    <= '0;
      accSum    <= '0;
      accHits   <= '0;
      accMiss   <= '0;
      accLate   <= '0;
      resMin    <= '0;
      resMax    <= '0;
      resSpread <= '0;
      resSum    <= '0;
      resHits   <= '0;
      resMiss   <= '0;
      resLate   <= '0;
      winDone   <= 1'b0;
    end else begin
      winDone <= strobe.winLatch;
      if (strobe.winLatch) begin
        resMin    <= (nHits == '0) ? '0 : nMin;
        resMax    <= (nHits == '0) ? '0 : nMax;
        resSpread <= (nHits == '0) ? '0 : nMax - nMin;
        resSum    <= nSum;
        resHits   <= nHits;
        resMiss   <= nMiss;
        resLate   <= nLate;
        accMin    <= '1;
        accMax    <= '0;
        accSum    <= '0;
        accHits   <= '0;
        accMiss   <= '0;
        accLate   <= '0;
      end else if (closeAny) begin
        accMin  <= nMin;
        accMax  <= nMax;
        accSum  <= nSum;
        accHits <= nHits;
        accMiss <= nMiss;
        accLate <= nLate;
      end
    end
  end

endmodule

// File: rtl/trig_latency_monitor.sv
module trig_latency_monitor
  import tlm_pkg::*;
#(
  parameter int TS_W    = 16,
  parameter int IDX_W   = 8,
  parameter int CFG_W   = 8,
  parameter int WIN_MIN = 10,
  parameter int WIN_MAX = 30,
  parameter int DATA_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmpIn,
  input  logic              markIn,
  input  logic              driveIn,
  input  logic [IDX_W-1:0]  arrIdx,
  input  logic [IDX_W-1:0]  tgtIdx,
  input  logic [CFG_W-1:0]  winLen,
  input  logic [TS_W-2:0]   timeoutCfg,
  input  logic [3:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              winDone
);

  localparam int CNT_W = $clog2(WIN_MAX + 1);
  localparam int SUM_W = TS_W + CNT_W;

  logic [2:0]       rise;
  tlm_strobe_t      strobe;
  logic [TS_W-1:0]  curLat, lastLat, lastExec, resMin, resMax, resSpread;
  logic [IDX_W-1:0] lastSlip;
  logic [SUM_W-1:0] resSum;
  logic [CNT_W-1:0] resHits, resMiss, resLate;

  tlm_edge_sync #(.N_IN(3)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   ({driveIn, markIn, cmpIn}),
    .riseOut (rise)
  );

  tlm_ctrl #(
    .TS_W(TS_W), .CFG_W(CFG_W), .WIN_MIN(WIN_MIN), .WIN_MAX(WIN_MAX), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .markRise   (rise[1]),
    .driveRise  (rise[2]),
    .curLat     (curLat),
    .timeoutCfg (timeoutCfg),
    .winLen     (winLen),
    .strobe     (strobe)
  );

  tlm_datapath #(
    .TS_W(TS_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .SUM_W(SUM_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmpRise   (rise[0]),
    .arrIdx    (arrIdx),
    .tgtIdx    (tgtIdx),
    .curLat    (curLat),
    .lastLat   (lastLat),
    .lastExec  (lastExec),
    .lastSlip  (lastSlip),
    .resMin    (resMin),
    .resMax    (resMax),
    .resSpread (resSpread),
    .resSum    (resSum),
    .resHits   (resHits),
    .resMiss   (resMiss),
    .resLate   (resLate),
    .winDone   (winDone)
  );

  always_comb begin
    case (rdAddr)
      RA_LAST_LAT:  rdData = DATA_W'(lastLat);
      RA_LAST_EXEC: rdData = DATA_W'(lastExec);
      RA_LAST_SLIP: rdData = {{(DATA_W-IDX_W){lastSlip[IDX_W-1]}}, lastSlip};
      RA_WIN_MIN:   rdData = DATA_W'(resMin);
      RA_WIN_MAX:   rdData = DATA_W'(resMax);
      RA_WIN_PP:    rdData = DATA_W'(resSpread);
      RA_WIN_SUM:   rdData = DATA_W'(resSum);
      RA_WIN_HITS:  rdData = DATA_W'(resHits);
      RA_WIN_MISS:  rdData = DATA_W'(resMiss);
      RA_WIN_LATE:  rdData = DATA_W'(resLate);
      default:      rdData = '0;
    endcase
  end

endmodule

// File: rtl/tlm_checker.sv
module tlm_checker #(
  parameter int TS_W    = 16,
  parameter int CFG_W   = 8,
  parameter int WIN_MIN = 10,
  parameter int WIN_MAX = 30,
  parameter int CNT_W   = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             winDone,
  input logic [CFG_W-1:0] winLen,
  input logic [TS_W-1:0]  resMin,
  input logic [TS_W-1:0]  resMax,
  input logic [CNT_W-1:0] resHits,
  input logic [CNT_W-1:0] resMiss,
  input logic [CNT_W-1:0] resLate,
  input logic             closeHit,
  input logic             closeMiss,
  input logic [TS_W-1:0]  lastLat,
  input logic [TS_W-2:0]  timeoutCfg
);

  logic [CFG_W-1:0] winLenQ;
  logic [CNT_W:0]   closedCnt;
  logic [CNT_W:0]   expWin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) winLenQ <= '0;
    else       winLenQ <= winLen;
  end

  assign closedCnt = {1'b0, resHits} + {1'b0, resMiss};

  always_comb begin
    if (winLenQ < CFG_W'(WIN_MIN))      expWin = (CNT_W+1)'(WIN_MIN);
    else if (winLenQ > CFG_W'(WIN_MAX)) expWin = (CNT_W+1)'(WIN_MAX);
    else                                expWin = (CNT_W+1)'(winLenQ);
  end

  assert_window_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    winDone |-> closedCnt == expWin);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    winDone |=> !winDone);

  assert_minmax_order_R9: assert property (@(posedge clk) disable iff (!rstN)
    (winDone && resHits != '0) |-> resMin <= resMax);

  assert_nohit_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (winDone && resHits == '0) |-> (resMin == '0 && resMax == '0));

  assert_close_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(closeHit && closeMiss));

  assert_hit_in_time_R5: assert property (@(posedge clk) disable iff (!rstN)
    closeHit |=> lastLat <= {1'b0, $past(timeoutCfg)});

  assert_late_bounded_R4: assert property (@(posedge clk) disable iff (!rstN)
    winDone |-> {1'b0, resLate} <= closedCnt);

endmodule

bind trig_latency_monitor tlm_checker #(
  .TS_W(TS_W), .CFG_W(CFG_W), .WIN_MIN(WIN_MIN), .WIN_MAX(WIN_MAX), .CNT_W(CNT_W)
) chk (
  .clk        (clk),
  .rstN       (rstN),
  .winDone    (winDone),
  .winLen     (winLen),
  .resMin     (resMin),
  .resMax     (resMax),
  .resHits    (resHits),
  .resMiss    (resMiss),
  .resLate    (resLate),
  .closeHit   (strobe.closeHit),
  .closeMiss  (strobe.closeMiss),
  .lastLat    (lastLat),
  .timeoutCfg (timeoutCfg)
);

// File: tb/trig_latency_monitor_test.sv
`timescale 1ns/1ps
module trig_latency_monitor_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmpIn = 1'b0, markIn = 1'b0, driveIn = 1'b0;
  logic [7:0]  arrIdx = '0, tgtIdx = '0;
  logic [7:0]  winLen = 8'd10;
  logic [14:0] timeoutCfg = 15'd20;
  logic [3:0]  rdAddr = '0;
  logic [23:0] rdData;
  logic        winDone;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  trig_latency_monitor uut (
    .clk(clk), .rstN(rstN), .cmpIn(cmpIn), .markIn(markIn), .driveIn(driveIn),
    .arrIdx(arrIdx), .tgtIdx(tgtIdx), .winLen(winLen), .timeoutCfg(timeoutCfg),
    .rdAddr(rdAddr), .rdData(rdData), .winDone(winDone)
  );

  always #10 clk = ~clk;

  // Behavioural reference state
  int k = 0;
  int hm[4], hd[4], hc[4];
  bit mOpen = 0;
  int mMarkT = 0, mCmpT = 0;
  bit mLate = 0;
  int mLastLat = 0, mExec = 0, mSlip = 0;
  int aMin = 0, aMax = 0, aSum = 0, aHits = 0, aMiss = 0, aLate = 0, aEvents = 0;
  int rMin = 0, rMax = 0, rSpread = 0, rSum = 0, rHits = 0, rMiss = 0, rLate = 0;
  bit mDone = 0;

  function automatic int clampWin(int w);
    if (w < 10) return 10;
    if (w > 30) return 30;
    return w;
  endfunction

  function automatic logic [23:0] regVal(int a);
    case (a)
      0: return 24'(mLastLat);
      1: return 24'(mExec);
      2: return (mSlip >= 128) ? (24'(mSlip) | 24'hFFFF00) : 24'(mSlip);
      3: return 24'(rMin);
      4: return 24'(rMax);
      5: return 24'(rSpread);
      6: return 24'(rSum);
      7: return 24'(rHits);
      8: return 24'(rMiss);
      9: return 24'(rLate);
      default: return 24'd0;
    endcase
  endfunction

  function automatic string tagOf(int a);
    case (a)
      0: return "R2 last latency";
      1: return "R3 exec delay";
      2: return "R4 slip";
      3: return "R9 window min";
      4: return "R9 window max";
      5: return "R9 spread";
      6: return "R9 sum";
      7: return "R9 hits";
      8: return "R5 misses";
      9: return "R4 late count";
      default: return "R9 unmapped reads zero";
    endcase
  endfunction

  task automatic chk(logic [23:0] act, logic [23:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelStep();
    int lat;
    bit mR, dR, cR, hit, miss;
    for (int i = 3; i > 0; i--) begin
      hm[i] = hm[i-1]; hd[i] = hd[i-1]; hc[i] = hc[i-1];
    end
    hm[0] = int'(markIn); hd[0] = int'(driveIn); hc[0] = int'(cmpIn);
    mR = (hm[2] == 1) && (hm[3] == 0);
    dR = (hd[2] == 1) && (hd[3] == 0);
    cR = (hc[2] == 1) && (hc[3] == 0);
    lat = (k - mMarkT) & 16'hFFFF;
    hit = 0; miss = 0; mDone = 0;
    if (mOpen) begin
      if (dR && lat <= int'(timeoutCfg)) hit = 1;
      else if (mR || lat > int'(timeoutCfg)) miss = 1;
    end
    if (hit) begin
      mLastLat = lat;
      if (aHits == 0 || lat < aMin) aMin = lat;
      if (aHits == 0 || lat > aMax) aMax = lat;
      aSum += lat;
      aHits++;
    end
    if (miss) aMiss++;
    if (hit || miss) begin
      mOpen = 0;
      if (mLate) aLate++;
      aEvents++;
      if (aEvents == clampWin(int'(winLen))) begin
        rMin = (aHits > 0) ? aMin : 0;
        rMax = (aHits > 0) ? aMax : 0;
        rSpread = rMax - rMin;
        rSum = aSum; rHits = aHits; rMiss = aMiss; rLate = aLate;
        aMin = 0; aMax = 0; aSum = 0; aHits = 0; aMiss = 0; aLate = 0; aEvents = 0;
        mDone = 1;
      end
    end
    if (mR) begin
      mOpen = 1;
      mMarkT = k;
      mLate = (arrIdx > tgtIdx);
      mSlip = (int'(arrIdx) - int'(tgtIdx)) & 255;
      mExec = (k - mCmpT) & 16'hFFFF;
    end
    if (cR) mCmpT = k;
    k++;
  endtask

  task automatic cycle();
    @(negedge clk);
    modelStep();
    chk(24'(winDone), 24'(mDone), "R8 window done pulse");
    chk(rdData, regVal(int'(rdAddr)), tagOf(int'(rdAddr)));
    rdAddr = (rdAddr == 4'd10) ? 4'd0 : rdAddr + 4'd1;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic peek(int a, string tag);
    rdAddr = 4'(a);
    #1;
    chk(rdData, regVal(a), tag);
  endtask

  task automatic evt(int lead, int lat, int arr, int tgt);
    cmpIn = 1'b1; tick(2); cmpIn = 1'b0; tick(lead);
    arrIdx = 8'(arr); tgtIdx = 8'(tgt);
    markIn = 1'b1; tick(2); markIn = 1'b0;
    if (lat > 0) begin
      tick(lat - 2); driveIn = 1'b1; tick(2); driveIn = 1'b0; tick(4);
    end else begin
      tick(int'(timeoutCfg) + 6);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog R1-chain run did not complete actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin hm[i] = 0; hd[i] = 0; hc[i] = 0; end
    repeat (3) @(negedge clk);
    for (int a = 0; a < 11; a++) peek(a, "R1 reset value");
    chk(24'(winDone), 24'd0, "R1 winDone in reset");
    rdAddr = 4'd0;
    rstN = 1'b1;

    // Window A: length 3 requested -> clamped to 10, timeout 20
    winLen = 8'd3; timeoutCfg = 15'd20;
    tick(3);
    evt(3, 5, 1, 1);  peek(0, "R2 latency 5");
    evt(5, 7, 2, 2);
    evt(1, 3, 3, 3);
    evt(2, 0, 4, 4);  peek(0, "R5 timeout miss keeps latency");
    evt(4, 12, 5, 5);
    evt(2, 6, 9, 4);  peek(2, "R4 positive slip"); peek(1, "R3 compare to marker");
    evt(3, 20, 6, 6); peek(0, "R5 hit at timeout");
    evt(3, 21, 7, 7); peek(0, "R5 drive after timeout ignored");
    driveIn = 1'b1; tick(2); driveIn = 1'b0; tick(4);
    peek(0, "R7 stray drive ignored");
    markIn = 1'b1; tick(2); markIn = 1'b0; tick(4);
    markIn = 1'b1; tick(2); markIn = 1'b0; tick(2);
    driveIn = 1'b1; tick(2); driveIn = 1'b0; tick(4);
    peek(8, "R6 overlapping marker counted as miss");
    peek(7, "R9 hits in clamped window of 10");
    peek(5, "R9 spread");
    peek(9, "R4 late count");

    // Window B: length 40 -> clamped to 30, all misses
    winLen = 8'd40; timeoutCfg = 15'd8;
    tick(4);
    for (int i = 0; i < 30; i++) begin
      markIn = 1'b1; tick(2); markIn = 1'b0; tick(2);
    end
    tick(15);
    peek(3, "R10 no-hit min is zero");
    peek(5, "R10 no-hit spread is zero");
    peek(8, "R8 window of 30 misses");

    // Window C: length 12, drive coincident with new marker
    winLen = 8'd12; timeoutCfg = 15'd30;
    tick(4);
    markIn = 1'b1; tick(2); markIn = 1'b0; tick(4);
    markIn = 1'b1; driveIn = 1'b1; tick(2); markIn = 1'b0; driveIn = 1'b0;
    tick(3); driveIn = 1'b1; tick(2); driveIn = 1'b0; tick(4);
    peek(0, "R6 same-cycle drive closes old event");
    for (int i = 0; i < 10; i++) begin
      evt(i % 4, 2 + i * 3, i, 5);
      if (i == 1) peek(2, "R4 negative slip");
    end
    tick(10);
    for (int a = 3; a < 11; a++) peek(a, "R9 window results after clear");

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule